// File: doc/BRIEF.md
# Register-Indirect Branch Decoder

This block takes one 32-bit instruction word from the unconditional register-branch group and turns it into a set of control signals for the execute stage. It first checks the fixed opcode bits. A word outside the group is handed back with a not-mine flag, so that a neighbouring decoder can claim it. A word inside the group is classified as an indirect jump, an indirect call or a return. The block then applies a set of legality rules. Each rule depends on a combination of fields and on whether the authentication feature is present.

For a legal word the block reports several results. These are the register index that holds the branch target and the source of the authentication modifier, either a register index or the stack pointer. It also reports whether authentication is requested and which of two keys to use. For a call it requests a link write of PC plus the instruction size. It also produces the two-bit branch-type tag that the landing-pad check applies at the destination. An authenticated return always takes its target from the link register and its modifier from the stack pointer. The block does no authentication arithmetic, no shadow-stack access and no register reads. Every output is registered and appears on the clock edge after the valid strobe.

Top module: `ribr_decoder`

## Requirements
- R1: A word is in the group only when bits 31:25 are 1101011, bit 23 is 0, bits 20:16 are 11111 and bits 15:12 are 0000. Any other valid word gives out_not_mine=1 with out_undef=0, out_taken=0 and out_link_we=0.
- R2: Bits 22:21 select the kind and are reported on out_kind with the same code: 00 indirect jump, 01 indirect call, 10 return. The code 11 is illegal.
- R3: When bit 11 (authenticate) is 0 and bits 4:0 (modifier index) are not 00000, the word is illegal.
- R4: When bit 11 is 1, the word is illegal if the authentication feature is absent. It is also illegal if bit 24 is 0 and bits 4:0 are not 11111.
- R5: An authenticated return is illegal unless bits 9:5 are 11111. When legal, out_tgt_idx is forced to 30 and out_mod_sp is 1.
- R6: Otherwise out_tgt_idx equals bits 9:5. out_mod_idx always equals bits 4:0. out_mod_sp is 1 when bit 24 is 1 and bits 4:0 are 11111.
- R7: out_auth reports bit 11. out_key_b reports bit 10, where 0 selects the first key and 1 selects the second.
- R8: A legal indirect call raises out_link_we and presents out_link_data = pc + 4.
- R9: out_btype is 10 for a call and 00 for a return. For a jump it is 01 when guarded_page is 0. When guarded_page is 1 it is 01 for target register 16 or 17 and 11 for any other register.
- R10: An illegal in-group word gives out_undef=1, out_taken=0 and out_link_we=0. A legal word gives out_taken=1 and out_undef=0.
- R11: Results appear on the rising edge after in_valid is sampled high, with out_valid high for one cycle per input. After an edge with in_valid low, out_valid, out_undef, out_taken, out_link_we and out_not_mine are all 0.
- R12: A low rst_n at a rising edge clears out_valid, out_undef, out_taken, out_link_we and out_not_mine, even when in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| pc | input | ADDR_W | Address of the instruction |
| guarded_page | input | 1 | Instruction sits in a guarded page |
| auth_present | input | 1 | Authentication feature is implemented |
| out_valid | output | 1 | Result registers hold a new result |
| out_not_mine | output | 1 | Word is outside the group |
| out_undef | output | 1 | Word is in the group but illegal |
| out_taken | output | 1 | Legal branch, take it |
| out_kind | output | 2 | 00 jump, 01 call, 10 return |
| out_tgt_idx | output | 5 | Register index of the target |
| out_mod_idx | output | 5 | Register index of the modifier |
| out_mod_sp | output | 1 | Modifier comes from the stack pointer |
| out_auth | output | 1 | Authenticate the target |
| out_key_b | output | 1 | Use the second key |
| out_link_we | output | 1 | Write the link register |
| out_link_data | output | ADDR_W | Value for the link register |
| out_btype | output | 2 | Next branch-type tag |

## Verification
Classification and legality can fall in the same cycle. A word can decode as an indirect call, and so ask for a link write, while an authentication rule makes it illegal. The bench sends an authenticated call with the feature absent, and then the same word with the feature present. It checks that the link write and taken are withdrawn in favour of undefined in the first case, and that both are granted in the second. The target override and the stack-pointer modifier can also apply together on an authenticated return. The bench checks that one word flips both.

// File: rtl/ribr_pkg.sv
package ribr_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned REG_W   = 5;

   // Fixed opcode fields of the group
   localparam logic [6:0] GRP_TOP  = 7'b1101011;
   localparam logic       GRP_B23  = 1'b0;
   localparam logic [4:0] GRP_MID  = 5'b11111;
   localparam logic [3:0] GRP_LOW  = 4'b0000;

   typedef enum logic [1:0] {
      BK_JUMP = 2'b00,
      BK_CALL = 2'b01,
      BK_RET  = 2'b10,
      BK_RSVD = 2'b11
   } br_kind_e;

   typedef enum logic [1:0] {
      LT_RET    = 2'b00,
      LT_JUMP   = 2'b01,
      LT_CALL   = 2'b10,
      LT_STRICT = 2'b11
   } land_tag_e;

   typedef struct packed {
      logic             zmod;
      br_kind_e         kind;
      logic             auth;
      logic             key_b;
      logic [REG_W-1:0] tgt;
      logic [REG_W-1:0] mod;
   } br_fields_t;

endpackage

// File: rtl/ribr_group_match.sv
module ribr_group_match
   import ribr_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output logic               in_group
);

   logic top_ok, b23_ok, mid_ok, low_ok;

   always_comb begin
      top_ok   = (instr[31:25] == GRP_TOP);
      b23_ok   = (instr[23]    == GRP_B23);
      mid_ok   = (instr[20:16] == GRP_MID);
      low_ok   = (instr[15:12] == GRP_LOW);
      in_group = top_ok & b23_ok & mid_ok & low_ok;
   end

endmodule

// File: rtl/ribr_legality.sv
module ribr_legality
   import ribr_pkg::*;
#(
   parameter int unsigned LINK_REG = 30
) (
   input  br_fields_t        f,
   input  logic              auth_ok,
   output logic              illegal,
   output logic [REG_W-1:0]  tgt_idx,
   output logic              mod_sp
);

   localparam logic [REG_W-1:0] SP_CODE  = {REG_W{1'b1}};
   localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

   logic bad_kind, bad_plain_mod, bad_no_feat, bad_auth_mod, bad_auth_ret;
   logic auth_ret;

   always_comb begin
      auth_ret      = f.auth & (f.kind == BK_RET);
      bad_kind      = (f.kind == BK_RSVD);
      bad_plain_mod = ~f.auth & (f.mod != '0);
      bad_no_feat   = f.auth & ~auth_ok;
      bad_auth_mod  = f.auth & ~f.zmod & (f.mod != SP_CODE);
      bad_auth_ret  = auth_ret & (f.tgt != SP_CODE);
      illegal       = bad_kind | bad_plain_mod | bad_no_feat
                    | bad_auth_mod | bad_auth_ret;
      tgt_idx       = auth_ret ? LINK_IDX : f.tgt;
      mod_sp        = (f.zmod & (f.mod == SP_CODE)) | auth_ret;
   end

endmodule

// File: rtl/ribr_tag_gen.sv
module ribr_tag_gen
   import ribr_pkg::*;
#(
   parameter int unsigned PAD_LO = 16,
   parameter int unsigned PAD_HI = 17
) (
   input  br_kind_e          kind,
   input  logic [REG_W-1:0]  src_reg,
   input  logic              guarded,
   output land_tag_e         tag
);

   logic pad_reg;

   always_comb begin
      pad_reg = (src_reg == REG_W'(PAD_LO)) | (src_reg == REG_W'(PAD_HI));
      unique case (kind)
         BK_CALL: tag = LT_CALL;
         BK_RET:  tag = LT_RET;
         BK_JUMP: tag = (guarded & ~pad_reg) ? LT_STRICT : LT_JUMP;
         default: tag = LT_RET;
      endcase
   end

endmodule

// File: rtl/ribr_decoder.sv
module ribr_decoder
   import ribr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned PC_STEP   = 4,
   parameter int unsigned AUTH_MODE = 0,   // 0 pin, 1 always present, 2 never
   parameter int unsigned LINK_REG  = 30,
   parameter int unsigned PAD_LO    = 16,
   parameter int unsigned PAD_HI    = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] pc,
   input  logic              guarded_page,
   input  logic              auth_present,
   output logic              out_valid,
   output logic              out_not_mine,
   output logic              out_undef,
   output logic              out_taken,
   output logic [1:0]        out_kind,
   output logic [4:0]        out_tgt_idx,
   output logic [4:0]        out_mod_idx,
   output logic              out_mod_sp,
   output logic              out_auth,
   output logic              out_key_b,
   output logic              out_link_we,
   output logic [ADDR_W-1:0] out_link_data,
   output logic [1:0]        out_btype
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);
   localparam int unsigned REG_CNT    = 1 << REG_W;

   if (ADDR_W < 8)            begin : g_chk_addr  $error("ADDR_W too small"); end
   if (AUTH_MODE > 2)         begin : g_chk_mode  $error("AUTH_MODE out of range"); end
   if (LINK_REG >= REG_CNT)   begin : g_chk_link  $error("LINK_REG out of range"); end
   if (PAD_LO >= REG_CNT || PAD_HI >= REG_CNT)
                              begin : g_chk_pad   $error("PAD register out of range"); end

   // Field split
   br_fields_t fld;
   always_comb begin
      fld.zmod  = instr[24];
      fld.kind  = br_kind_e'(instr[22:21]);
      fld.auth  = instr[11];
      fld.key_b = instr[10];
      fld.tgt   = instr[9:5];
      fld.mod   = instr[4:0];
   end

   // Authentication feature source
   logic auth_ok;
   if (AUTH_MODE == 1) begin : g_auth_on
      assign auth_ok = 1'b1;
   end else if (AUTH_MODE == 2) begin : g_auth_off
      assign auth_ok = 1'b0;
   end else begin : g_auth_pin
      assign auth_ok = auth_present;
   end

   logic             in_group;
   logic             illegal;
   logic [REG_W-1:0] tgt_idx;
   logic             mod_sp;
   land_tag_e        tag;

   ribr_group_match u_match (
      .instr    (instr),
      .in_group (in_group)
   );

   ribr_legality #(.LINK_REG(LINK_REG)) u_legal (
      .f        (fld),
      .auth_ok  (auth_ok),
      .illegal  (illegal),
      .tgt_idx  (tgt_idx),
      .mod_sp   (mod_sp)
   );

   ribr_tag_gen #(.PAD_LO(PAD_LO), .PAD_HI(PAD_HI)) u_tag (
      .kind     (fld.kind),
      .src_reg  (fld.tgt),
      .guarded  (guarded_page),
      .tag      (tag)
   );

   logic ok_now;
   assign ok_now = in_group & ~illegal;

   // Control flags: cleared by reset and on idle cycles
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_not_mine <= 1'b0;
         out_undef    <= 1'b0;
         out_taken    <= 1'b0;
         out_link_we  <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         out_not_mine <= in_valid & ~in_group;
         out_undef    <= in_valid & in_group & illegal;
         out_taken    <= in_valid & ok_now;
         out_link_we  <= in_valid & ok_now & (fld.kind == BK_CALL);
      end
   end

   // Data fields: captured on valid, held otherwise
   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_kind      <= fld.kind;
         out_tgt_idx   <= tgt_idx;
         out_mod_idx   <= fld.mod;
         out_mod_sp    <= mod_sp;
         out_auth      <= fld.auth;
         out_key_b     <= fld.key_b;
         out_link_data <= pc + STEP;
         out_btype     <= tag;
      end
   end

endmodule

// File: rtl/ribr_decoder_chk.sv
module ribr_decoder_chk #(
   parameter int unsigned ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] pc,
   input logic              out_valid,
   input logic              out_not_mine,
   input logic              out_undef,
   input logic              out_taken,
   input logic [1:0]        out_kind,
   input logic [4:0]        out_tgt_idx,
   input logic              out_mod_sp,
   input logic              out_auth,
   input logic              out_link_we,
   input logic [ADDR_W-1:0] out_link_data,
   input logic [1:0]        out_btype
);

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));                          // R11

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones({out_taken, out_undef, out_not_mine}) == 1));    // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_taken | out_undef | out_not_mine | out_link_we));     // R11

   AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_link_we |-> (out_taken && out_kind == 2'b01));                         // R8

   AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_link_we && $past(rst_n)) |-> (out_link_data == $past(pc) + ADDR_W'(4))); // R8

   AST_RET_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken && out_kind == 2'b10) |-> (out_btype == 2'b00));                 // R9

   AST_CALL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken && out_kind == 2'b01) |-> (out_btype == 2'b10));                 // R9

   AST_AUTH_RET_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken && out_auth && out_kind == 2'b10) |->
         (out_tgt_idx == 5'd30 && out_mod_sp));                                  // R5

   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst_n) == 1'b0 && $past(in_valid) |-> !out_valid || $past(rst_n));   // R12

endmodule

bind ribr_decoder ribr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .pc            (pc),
   .out_valid     (out_valid),
   .out_not_mine  (out_not_mine),
   .out_undef     (out_undef),
   .out_taken     (out_taken),
   .out_kind      (out_kind),
   .out_tgt_idx   (out_tgt_idx),
   .out_mod_sp    (out_mod_sp),
   .out_auth      (out_auth),
   .out_link_we   (out_link_we),
   .out_link_data (out_link_data),
   .out_btype     (out_btype)
);

// File: tb/ribr_decoder_tb.sv
module ribr_decoder_tb;

   localparam int unsigned AW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   instr = '0;
   logic [AW-1:0] pc = '0;
   logic          guarded_page = 1'b0;
   logic          auth_present = 1'b0;

   logic          out_valid, out_not_mine, out_undef, out_taken;
   logic [1:0]    out_kind, out_btype;
   logic [4:0]    out_tgt_idx, out_mod_idx;
   logic          out_mod_sp, out_auth, out_key_b, out_link_we;
   logic [AW-1:0] out_link_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ribr_decoder #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .guarded_page(guarded_page), .auth_present(auth_present),
      .out_valid(out_valid), .out_not_mine(out_not_mine), .out_undef(out_undef),
      .out_taken(out_taken), .out_kind(out_kind), .out_tgt_idx(out_tgt_idx),
      .out_mod_idx(out_mod_idx), .out_mod_sp(out_mod_sp), .out_auth(out_auth),
      .out_key_b(out_key_b), .out_link_we(out_link_we),
      .out_link_data(out_link_data), .out_btype(out_btype)
   );

   function automatic logic [31:0] enc(input logic z, input logic [1:0] op,
                                       input logic a, input logic kb,
                                       input logic [4:0] rt, input logic [4:0] rm);
      return {7'b1101011, z, 1'b0, op, 5'b11111, 4'b0000, a, kb, rt, rm};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive one word, return after the capture edge
   task automatic send(input logic [31:0] w, input logic [AW-1:0] p,
                       input logic gp, input logic feat);
      @(negedge clk);
      instr = w; pc = p; guarded_page = gp; auth_present = feat; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R12", "valid after reset", out_valid, 0);
      chk("R12", "undef after reset", out_undef, 0);
      chk("R12", "link_we after reset", out_link_we, 0);
      // reset wins over a valid call word
      @(negedge clk);
      instr = enc(0, 2'b01, 0, 0, 5'd2, 5'd0); in_valid = 1'b1; rst_n = 1'b0;
      @(negedge clk);
      chk("R12", "valid under reset", out_valid, 0);
      chk("R12", "link_we under reset", out_link_we, 0);
      chk("R12", "taken under reset", out_taken, 0);
      in_valid = 1'b0; rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_plain_return;
      send(enc(0, 2'b10, 0, 0, 5'd30, 5'd0), 64'h100, 0, 0);
      chk("R11", "valid", out_valid, 1);
      chk("R2", "kind ret", out_kind, 2'b10);
      chk("R10", "taken", out_taken, 1);
      chk("R6", "tgt", out_tgt_idx, 30);
      chk("R6", "mod_sp", out_mod_sp, 0);
      chk("R9", "btype ret", out_btype, 2'b00);
      chk("R8", "no link on ret", out_link_we, 0);
      @(negedge clk);
      chk("R11", "idle valid", out_valid, 0);
      chk("R11", "idle taken", out_taken, 0);
   endtask

   task automatic t_call;
      send(enc(0, 2'b01, 0, 0, 5'd5, 5'd0), 64'h0000_1234_0000_1000, 1, 0);
      chk("R2", "kind call", out_kind, 2'b01);
      chk("R8", "link_we", out_link_we, 1);
      chk("R8", "link data", out_link_data, 64'h0000_1234_0000_1004);
      chk("R9", "btype call", out_btype, 2'b10);
      chk("R6", "tgt call", out_tgt_idx, 5);
   endtask

   task automatic t_jump_tags;
      send(enc(0, 2'b00, 0, 0, 5'd3, 5'd0), 64'h0, 0, 0);
      chk("R9", "jump unguarded r3", out_btype, 2'b01);
      chk("R2", "kind jump", out_kind, 2'b00);
      send(enc(0, 2'b00, 0, 0, 5'd3, 5'd0), 64'h0, 1, 0);
      chk("R9", "jump guarded r3", out_btype, 2'b11);
      send(enc(0, 2'b00, 0, 0, 5'd16, 5'd0), 64'h0, 1, 0);
      chk("R9", "jump guarded r16", out_btype, 2'b01);
      send(enc(0, 2'b00, 0, 0, 5'd17, 5'd0), 64'h0, 1, 0);
      chk("R9", "jump guarded r17", out_btype, 2'b01);
      send(enc(0, 2'b00, 0, 0, 5'd18, 5'd0), 64'h0, 1, 0);
      chk("R9", "jump guarded r18", out_btype, 2'b11);
   endtask

   task automatic t_illegal_plain;
      send(enc(0, 2'b11, 0, 0, 5'd1, 5'd0), 64'h0, 0, 1);
      chk("R2", "op 11 undef", out_undef, 1);
      chk("R10", "op 11 not taken", out_taken, 0);
      send(enc(0, 2'b00, 0, 0, 5'd1, 5'd4), 64'h0, 0, 1);
      chk("R3", "plain nonzero mod undef", out_undef, 1);
      send(enc(0, 2'b01, 0, 0, 5'd1, 5'd1), 64'h40, 0, 1);
      chk("R3", "plain call nonzero mod undef", out_undef, 1);
      chk("R10", "no link when illegal", out_link_we, 0);
   endtask

   task automatic t_auth_rules;
      send(enc(0, 2'b00, 1, 0, 5'd4, 5'd31), 64'h0, 0, 0);
      chk("R4", "auth without feature", out_undef, 1);
      send(enc(0, 2'b00, 1, 0, 5'd4, 5'd31), 64'h0, 0, 1);
      chk("R4", "auth with feature taken", out_taken, 1);
      chk("R7", "auth flag", out_auth, 1);
      chk("R7", "key a", out_key_b, 0);
      chk("R6", "mod idx", out_mod_idx, 31);
      chk("R6", "mod_sp needs z", out_mod_sp, 0);
      send(enc(0, 2'b00, 1, 0, 5'd4, 5'd7), 64'h0, 0, 1);
      chk("R4", "auth z0 mod not 31", out_undef, 1);
      send(enc(1, 2'b00, 1, 1, 5'd4, 5'd9), 64'h0, 0, 1);
      chk("R4", "auth z1 any mod legal", out_taken, 1);
      chk("R7", "key b", out_key_b, 1);
      chk("R6", "mod idx 9", out_mod_idx, 9);
      chk("R6", "mod reg", out_mod_sp, 0);
      send(enc(1, 2'b00, 1, 0, 5'd4, 5'd31), 64'h0, 0, 1);
      chk("R6", "mod from sp", out_mod_sp, 1);
   endtask

   task automatic t_auth_return;
      send(enc(0, 2'b10, 1, 1, 5'd31, 5'd31), 64'h0, 0, 1);
      chk("R5", "auth ret taken", out_taken, 1);
      chk("R5", "auth ret tgt forced", out_tgt_idx, 30);
      chk("R5", "auth ret mod sp", out_mod_sp, 1);
      chk("R9", "auth ret btype", out_btype, 2'b00);
      send(enc(0, 2'b10, 1, 0, 5'd30, 5'd31), 64'h0, 0, 1);
      chk("R5", "auth ret wrong reg", out_undef, 1);
   endtask

   task automatic t_collision;
      send(enc(1, 2'b01, 1, 0, 5'd8, 5'd31), 64'h2000, 0, 0);
      chk("R10", "call+illegal undef", out_undef, 1);
      chk("R10", "call+illegal no link", out_link_we, 0);
      chk("R10", "call+illegal not taken", out_taken, 0);
      send(enc(1, 2'b01, 1, 0, 5'd8, 5'd31), 64'h2000, 0, 1);
      chk("R8", "auth call link", out_link_we, 1);
      chk("R8", "auth call data", out_link_data, 64'h2004);
      chk("R6", "auth call mod sp", out_mod_sp, 1);
   endtask

   task automatic t_not_mine;
      send(32'h8B00_0000, 64'h0, 0, 1);
      chk("R1", "foreign not_mine", out_not_mine, 1);
      chk("R1", "foreign undef", out_undef, 0);
      send(enc(0, 2'b01, 0, 0, 5'd2, 5'd0) | 32'h0080_0000, 64'h0, 0, 1);
      chk("R1", "bit23 not_mine", out_not_mine, 1);
      chk("R1", "bit23 link", out_link_we, 0);
      send(enc(0, 2'b00, 0, 0, 5'd2, 5'd0) | 32'h0000_1000, 64'h0, 0, 1);
      chk("R1", "bits15:12 not_mine", out_not_mine, 1);
      send(enc(0, 2'b00, 0, 0, 5'd2, 5'd0) & ~32'h0001_0000, 64'h0, 0, 1);
      chk("R1", "bits20:16 not_mine", out_not_mine, 1);
      chk("R1", "bits20:16 taken", out_taken, 0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      instr = enc(0, 2'b01, 0, 0, 5'd6, 5'd0); pc = 64'h300; in_valid = 1'b1;
      @(negedge clk);
      chk("R11", "b2b first link", out_link_we, 1);
      chk("R11", "b2b first tgt", out_tgt_idx, 6);
      instr = enc(0, 2'b10, 0, 0, 5'd30, 5'd0); pc = 64'h304;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R11", "b2b second valid", out_valid, 1);
      chk("R11", "b2b second kind", out_kind, 2'b10);
      chk("R11", "b2b second link", out_link_we, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_plain_return;
      t_call;
      t_jump_tags;
      t_illegal_plain;
      t_auth_rules;
      t_auth_return;
      t_collision;
      t_not_mine;
      t_back_to_back;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule